// File: doc/BRIEF.md
# Unaligned Write Word Packer

The packer takes a byte-granular write request, made of a start byte address, a byte length and a stream of data bytes with a valid/ready handshake. It turns the request into a series of program requests for a downstream word programmer. Each program request carries a whole 4-byte word at a 4-byte-aligned address. Byte lanes that the request does not cover are filled with 0xFF, the erased value, so the programmer leaves flash outside the request unchanged.

A request moves through a head word, then body words, then a tail word. The head word is partial when the start address is unaligned. Body words are whole words taken straight from the stream. The tail word holds the last one to three bytes. The packer keeps a count of the request bytes that were programmed successfully, and it stops at the first word the programmer reports as failed. Two kinds of request are settled without any program request: one that runs past the end of the array, and one of zero length. Completion is signalled by a one-cycle `done` pulse together with a 2-bit status.

Top module: `wr_word_packer`

## Requirements
- R1: Every program request carries an address whose two low bits are zero. The first word goes to the start address rounded down, and each later word goes to the previous word address plus 4.
- R2: Byte lanes are little-endian: the byte at word address +k sits in bits 8k+7:8k of `pg_data`. In the first word, the lanes below the start offset are 0xFF, and any lane past the request's end is also 0xFF.
- R3: While at least 4 request bytes remain at a word boundary, the next word is built entirely from the next 4 stream bytes, in stream order.
- R4: When 1 to 3 bytes are left at a word boundary, they fill the low lanes of a final word and the upper lanes are 0xFF.
- R5: `bytes_done` is cleared when a request is accepted. It grows only when a word is acknowledged without error, and only by the number of request bytes in that word, never by padding.
- R6: If start address plus length exceeds `ARRAY_BYTES`, the request is refused. No program request is made, no stream byte is taken, `done_status` is 2'b01 and `bytes_done` is 0.
- R7: A zero-length request completes with `done_status` 2'b00 and `bytes_done` 0, with no program request and no stream byte taken.
- R8: An acknowledge with `pg_err` high ends the request with `done_status` 2'b10. No further program request is made, and `bytes_done` counts only the words acknowledged before the failed one.
- R9: While `pg_req` is high, `s_ready` is low, and `pg_addr` and `pg_data` hold steady until `pg_ack`.
- R10: `done` pulses for exactly one cycle. It arrives in the cycle after the final acknowledge, or in the cycle after a refused or zero-length request is accepted. A normal completion reports 2'b00. `req_ready` is high only while the packer is idle. After reset, `req_ready` is 1 and `pg_req`, `s_ready`, `done` and `bytes_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Packer idle; a request is accepted when valid and ready are both high |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| s_valid | input | 1 | Stream byte present |
| s_ready | output | 1 | Packer takes a stream byte |
| s_data | input | 8 | Stream byte |
| pg_req | output | 1 | Word program request |
| pg_addr | output | ADDR_W | Aligned word address |
| pg_data | output | 32 | Packed word |
| pg_ack | input | 1 | Programmer finished the word |
| pg_err | input | 1 | Word program failed; valid with `pg_ack` |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 ok, 01 out of range, 10 program error |
| bytes_done | output | LEN_W | Request bytes programmed successfully |

## Verification
Each result has a known arrival time, and the checks sample it then. A stream byte is taken at the clock edge where `s_valid` and `s_ready` are both high. A word's `pg_req` rises one edge after its last byte is taken. `done` and the updated `bytes_done` appear one edge after the acknowledge that ends the request, or one edge after a refused or zero-length request is accepted. The bench drives and samples on the falling edge and keeps a cycle counter, so the distance from the final acknowledge, or from request acceptance, to `done` is checked to be exactly one cycle. Programmer latency is varied, so the bench also confirms that the word stays stable and the stream stays stalled across long waits.

// File: rtl/wr_word_packer.sv
module wr_word_packer #(
  parameter int ADDR_W      = 21,
  parameter int ARRAY_BYTES = 2097152,
  parameter int LEN_W       = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              pg_req,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [31:0]       pg_data,
  input  logic              pg_ack,
  input  logic              pg_err,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [LEN_W-1:0]  bytes_done
);
  localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(ARRAY_BYTES);
  localparam logic [1:0] ST_OK = 2'b00, ST_RANGE = 2'b01, ST_IO = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROG} st_t;
  st_t st;

  logic [ADDR_W-1:0] waddr;
  logic [1:0]        lane;
  logic [LEN_W-1:0]  left;
  logic [31:0]       word;
  logic [2:0]        wcnt;
  logic [LEN_W:0]    end_pos;

  assign end_pos   = {{(LEN_W+1-ADDR_W){1'b0}}, req_addr} + {1'b0, req_len};
  assign req_ready = (st == S_IDLE);
  assign s_ready   = (st == S_FILL);
  assign pg_req    = (st == S_PROG);
  assign pg_addr   = waddr;
  assign pg_data   = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      waddr       <= '0;
      lane        <= '0;
      left        <= '0;
      word        <= '1;
      wcnt        <= '0;
      done        <= 1'b0;
      done_status <= ST_OK;
      bytes_done  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          bytes_done <= '0;
          if (req_len == '0) begin
            done        <= 1'b1;
            done_status <= ST_OK;
          end else if (end_pos > LIMIT) begin
            done        <= 1'b1;
            done_status <= ST_RANGE;
          end else begin
            waddr <= {req_addr[ADDR_W-1:2], 2'b00};
            lane  <= req_addr[1:0];
            left  <= req_len;
            word  <= '1;
            wcnt  <= '0;
            st    <= S_FILL;
          end
        end
        S_FILL: if (s_valid) begin
          word[lane*8 +: 8] <= s_data;
          left <= left - 1'b1;
          wcnt <= wcnt + 1'b1;
          lane <= lane + 1'b1;
          if (lane == 2'd3 || left == LEN_W'(1)) st <= S_PROG;
        end
        S_PROG: if (pg_ack) begin
          if (pg_err) begin
            done        <= 1'b1;
            done_status <= ST_IO;
            st          <= S_IDLE;
          end else begin
            bytes_done <= bytes_done + LEN_W'(wcnt);
            if (left == '0) begin
              done        <= 1'b1;
              done_status <= ST_OK;
              st          <= S_IDLE;
            end else begin
              waddr <= waddr + ADDR_W'(4);
              lane  <= '0;
              word  <= '1;
              wcnt  <= '0;
              st    <= S_FILL;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req |-> pg_addr[1:0] == 2'b00);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && !pg_ack) |=> pg_req && !s_ready && $stable(pg_addr) && $stable(pg_data));

  // R5
  a_r5_count_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !(pg_req && pg_ack && !pg_err)) |=> $stable(bytes_done));

  // R8
  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && pg_ack && pg_err) |=> !pg_req && done && done_status == 2'b10);

  // R6
  a_r6_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 2'b01) |-> bytes_done == '0);

  // R10
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_wr_word_packer.sv
module tb_wr_word_packer;
  localparam int ADDR_W = 21;
  localparam int LEN_W  = 22;
  localparam int ARRAY_BYTES = 2097152;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, s_valid = 0, pg_ack = 0, pg_err = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [7:0]        s_data = '0;
  logic req_ready, s_ready, pg_req, done;
  logic [ADDR_W-1:0] pg_addr;
  logic [31:0] pg_data;
  logic [1:0] done_status;
  logic [LEN_W-1:0] bytes_done;

  wr_word_packer #(.ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .pg_req(pg_req), .pg_addr(pg_addr), .pg_data(pg_data),
    .pg_ack(pg_ack), .pg_err(pg_err), .done(done), .done_status(done_status),
    .bytes_done(bytes_done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // programmer model state
  int ack_delay = 0, fail_at = -1, nlog = 0, wait_cnt = 0, last_ack_cyc = 0;
  logic [ADDR_W-1:0] log_addr [16];
  logic [31:0]       log_data [16];
  logic [31:0]       first_data;
  logic              seen_req = 0;
  // completion monitor
  logic dn_seen = 0;
  logic [1:0] dn_status;
  logic [LEN_W-1:0] dn_bytes;
  int dn_cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial forever begin
    @(negedge clk);
    if (pg_ack) begin pg_ack = 0; pg_err = 0; end
    else if (pg_req) begin
      if (!seen_req) begin seen_req = 1; first_data = pg_data; wait_cnt = 0; end
      if (wait_cnt >= ack_delay) begin
        chk(!s_ready, "R9", "s_ready during program", {31'b0, s_ready}, 32'h0);
        chk(pg_data == first_data, "R9", "data stable", pg_data, first_data);
        if (nlog < 16) begin log_addr[nlog] = pg_addr; log_data[nlog] = pg_data; end
        pg_err = (nlog == fail_at);
        pg_ack = 1;
        nlog++;
        seen_req = 0;
        last_ack_cyc = cyc;
      end else wait_cnt++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) begin dn_seen = 1; dn_status = done_status; dn_bytes = bytes_done; dn_cyc = cyc; end
  end

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'((v * 37 + k * 13 + 5) & 255);
  endfunction

  // issue one request, feed the stream, wait for done; returns cycle of acceptance
  task automatic run_req(input int v, input int addr, input int len, input int fail,
                         input int dly, output int acc_cyc, output int taken);
    int k = 0, guard = 0;
    bit acc;
    nlog = 0; fail_at = fail; ack_delay = dly; dn_seen = 0; taken = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 0;
    while (!dn_seen && guard < 2000) begin
      if (k < len) begin s_valid = 1; s_data = pat(v, k); end else s_valid = 0;
      acc = s_valid && s_ready;
      @(posedge clk);
      if (acc) k++;
      @(negedge clk);
      guard++;
    end
    s_valid = 0;
    taken = k;
  endtask

  function automatic logic [31:0] exp_word(input int v, input int addr, input int len, input int w);
    logic [31:0] r;
    int base = (addr & ~3) + 4 * w;
    for (int l = 0; l < 4; l++) begin
      int p = base + l;
      r[l*8 +: 8] = (p >= addr && p < addr + len) ? pat(v, p - addr) : 8'hFF;
    end
    return r;
  endfunction

  task automatic check_ok(input int v, input int addr, input int len);
    int nw = ((addr + len - 1) >> 2) - (addr >> 2) + 1;
    chk(dn_seen, "R10", "done seen", {31'b0, dn_seen}, 32'h1);
    chk(nlog == nw, "R1", "word count", nlog, nw);
    for (int w = 0; w < nw && w < nlog; w++) begin
      logic [31:0] e = exp_word(v, addr, len, w);
      string tg = (w == 0 && (addr & 3) != 0) ? "R2" :
                  ((w == nw - 1 && ((addr + len) & 3) != 0) ? "R4" : "R3");
      chk(32'(log_addr[w]) == 32'((addr & ~3) + 4 * w), "R1", "word address",
          32'(log_addr[w]), 32'((addr & ~3) + 4 * w));
      chk(log_data[w] == e, tg, "word data", log_data[w], e);
    end
    chk(dn_status == 2'b00, "R10", "ok status", {30'b0, dn_status}, 32'h0);
    chk(dn_bytes == LEN_W'(len), "R5", "bytes_done", 32'(dn_bytes), len);
    chk(dn_cyc - last_ack_cyc == 1, "R10", "done latency", dn_cyc - last_ack_cyc, 1);
  endtask

  localparam logic [28:0] VEC [10] = '{
    {21'h000000, 8'd8}, {21'h000001, 8'd2}, {21'h000002, 8'd7}, {21'h000003, 8'd1},
    {21'h000005, 8'd12}, {21'h000010, 8'd3}, {21'h000006, 8'd2}, {21'h1FFFFC, 8'd4},
    {21'h000001, 8'd16}, {21'h000020, 8'd4}};

  initial begin
    int acc_cyc, taken;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !pg_req && !s_ready && !done && bytes_done == 0, "R10", "reset state",
        {req_ready, pg_req, s_ready, done}, 4'b1000);
    rst_n = 1;

    for (int v = 0; v < 10; v++) begin
      int a = int'(VEC[v][28:8]);
      int l = int'(VEC[v][7:0]);
      run_req(v, a, l, -1, v % 4, acc_cyc, taken);
      check_ok(v, a, l);
    end

    // R7 zero length
    run_req(20, 8, 0, -1, 0, acc_cyc, taken);
    chk(dn_status == 2'b00 && dn_bytes == 0, "R7", "zero length result", {dn_status, 30'(dn_bytes)}, 0);
    chk(nlog == 0 && taken == 0, "R7", "zero length no program", nlog, 0);
    chk(dn_cyc - acc_cyc == 1, "R10", "zero length latency", dn_cyc - acc_cyc, 1);

    // R6 out of range
    run_req(21, 21'h1FFFFE, 4, -1, 0, acc_cyc, taken);
    chk(dn_status == 2'b01, "R6", "range status", dn_status, 2'b01);
    chk(dn_bytes == 0 && nlog == 0 && taken == 0, "R6", "range no activity",
        {16'(nlog), 16'(taken)}, 0);
    chk(dn_cyc - acc_cyc == 1, "R10", "range latency", dn_cyc - acc_cyc, 1);

    // R8 failure on second word: head 3 bytes ok, then fail
    run_req(22, 1, 10, 1, 2, acc_cyc, taken);
    chk(dn_status == 2'b10, "R8", "error status", dn_status, 2'b10);
    chk(dn_bytes == 3, "R8", "bytes before failure", 32'(dn_bytes), 3);
    chk(nlog == 2, "R8", "no program after failure", nlog, 2);
    chk(taken == 7, "R8", "stream stops after failure", taken, 7);
    chk(dn_cyc - last_ack_cyc == 1, "R10", "error latency", dn_cyc - last_ack_cyc, 1);

    // R5 failure on first word counts nothing
    run_req(23, 0, 6, 0, 0, acc_cyc, taken);
    chk(dn_status == 2'b10 && dn_bytes == 0, "R5", "first word failure count",
        32'(dn_bytes), 0);

    // recovery after error
    run_req(24, 3, 5, -1, 1, acc_cyc, taken);
    check_ok(24, 3, 5);

    finish_sim();
  end
endmodule